// File: doc/BRIEF.md
# USB Device Address Register Unit

This block stores the device address and the device-enable flag of a full-speed USB peripheral controller. A microcontroller reaches it through a command/data port. It first issues a command byte, then moves exactly one data word. One command code writes the register and another reads it back. Only the low byte of the data bus carries the register; the upper byte is ignored on writes and returned as zero on reads.

A write does not take effect at once. The written byte is held as a pending value. It is copied into the active register only when the controller signals that the host has acknowledged the zero-length status packet that ends the Set Address request. Until then, the transfer in progress still completes on the old address.

A USB bus reset puts the active register back to address zero with the device enabled, and it throws away any pending value. A combinational comparator checks each incoming token address against the active address. It reports a match only while the device is enabled.

Top module: `usb_addr_unit`

## Requirements
- R1: After a `cmd_valid` cycle with `cmd_code` = 0xB6, the next data write updates the register. After one with 0xB7, the next data read returns it. Any other code makes the following data access change nothing and return no read data (`rd_valid` stays 0 and `rd_data` stays 0).
- R2: On a write, only `wr_data[7:0]` is stored; the bits above bit 7 are ignored.
- R3: A read raises `rd_valid` for one cycle, one clock after `rd_req`. In that cycle `rd_data[7:0]` holds the most recently written byte, even if it is still pending, and the upper bits are zero. Outside a valid read, `rd_data` is zero.
- R4: A written byte does not change `dev_en` or `dev_addr` until a `status_ack` pulse. The active register takes the pending byte on the clock edge of that pulse. A `status_ack` with nothing pending changes nothing.
- R5: In the register byte, bit 7 is the device enable and drives `dev_en`. Bits 6:0 are the device address and drive `dev_addr`.
- R6: A `bus_reset` cycle sets the active register to 0x80 (enabled, address 0) on the next edge. It discards any pending byte, so a later `status_ack` changes nothing, and a later read returns 0x80. It also cancels a command that is waiting for its data access.
- R7: After power-on reset (`rst_n` low), `dev_en` is 0, `dev_addr` is 0, `rd_valid` is 0, and `addr_match` is 0.
- R8: `addr_match` is 1 only when `tok_valid` is 1, `dev_en` is 1, and `tok_addr` equals `dev_addr`. It follows its inputs in the same cycle.
- R9: A command covers only one data access. A second write or read without a new command has no effect and returns no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | 16 | Data write word |
| rd_req | input | 1 | Data read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after rd_req |
| rd_data | output | 16 | Read data word |
| bus_reset | input | 1 | USB bus reset seen on the line |
| status_ack | input | 1 | Host acknowledged zero-length IN status packet on endpoint 0 |
| tok_valid | input | 1 | Token address valid |
| tok_addr | input | 7 | Address field of the received token |
| addr_match | output | 1 | Token addressed to this device |
| dev_en | output | 1 | Active device enable |
| dev_addr | output | 7 | Active device address |

## Verification
The hardest case to reach is a pending byte overtaken by other events. Examples are a second write before the acknowledge, a bus reset between write and acknowledge, an acknowledge with nothing pending, or a data access whose command was cancelled by a bus reset. Random sequences of commands (including unknown codes), writes with random upper bytes, reads, acknowledges, bus resets and token probes build these interleavings. Directed sequences hit each one on purpose. A bench model of the pending and active bytes gives the expected read data, active address and match result after every step.

// File: rtl/usb_addr_pkg.sv
package usb_addr_pkg;
  localparam int ADDR_W = 7;
  localparam int REG_W  = ADDR_W + 1;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_e;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
  } dev_reg_t;

  localparam dev_reg_t BUS_RESET_VAL = '{en: 1'b1, addr: '0};
endpackage

// File: rtl/usb_addr_cmd_dec.sv
module usb_addr_cmd_dec
  import usb_addr_pkg::*;
#(
  parameter int             CMD_W  = 8,
  parameter logic [CMD_W-1:0] CMD_WR = 8'hB6,
  parameter logic [CMD_W-1:0] CMD_RD = 8'hB7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             wr_valid,
  input  logic             rd_req,
  output logic             wr_fire,
  output logic             rd_fire
);
  acc_e acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (wr_valid || rd_req) acc_d = ACC_NONE;
    if (cmd_valid) begin
      if (cmd_code == CMD_WR)      acc_d = ACC_WRITE;
      else if (cmd_code == CMD_RD) acc_d = ACC_READ;
      else                         acc_d = ACC_NONE;
    end
    if (bus_reset) acc_d = ACC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= ACC_NONE;
    else        acc_q <= acc_d;
  end

  assign wr_fire = wr_valid && !bus_reset && (acc_q == ACC_WRITE);
  assign rd_fire = rd_req   && !bus_reset && (acc_q == ACC_READ);

  // R9
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !cmd_valid) |=> !wr_fire);
  // R9
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !cmd_valid) |=> !rd_fire);
  // R6
  reset_cancels_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !cmd_valid) |=> !(wr_fire || rd_fire));
endmodule

// File: rtl/usb_addr_regs.sv
module usb_addr_regs
  import usb_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             wr_fire,
  input  logic [REG_W-1:0] wr_byte,
  input  logic             rd_fire,
  input  logic             status_ack,
  output dev_reg_t         act,
  output logic             rd_valid,
  output logic [REG_W-1:0] rd_byte
);
  logic [REG_W-1:0] shadow_q, shadow_d;
  logic             pend_q, pend_d;
  dev_reg_t         act_q, act_d;
  logic             rdv_q, rdv_d;
  logic [REG_W-1:0] rdb_q, rdb_d;

  always_comb begin
    shadow_d = shadow_q;
    pend_d   = pend_q;
    act_d    = act_q;
    rdv_d    = rd_fire;
    rdb_d    = rd_fire ? shadow_q : '0;
    if (status_ack && pend_q) begin
      act_d  = dev_reg_t'(shadow_q);
      pend_d = 1'b0;
    end
    if (wr_fire) begin
      shadow_d = wr_byte;
      pend_d   = 1'b1;
    end
    if (bus_reset) begin
      act_d    = BUS_RESET_VAL;
      shadow_d = REG_W'(BUS_RESET_VAL);
      pend_d   = 1'b0;
      rdv_d    = 1'b0;
      rdb_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pend_q   <= 1'b0;
      act_q    <= '0;
      rdv_q    <= 1'b0;
      rdb_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      pend_q   <= pend_d;
      act_q    <= act_d;
      rdv_q    <= rdv_d;
      rdb_q    <= rdb_d;
    end
  end

  assign act      = act_q;
  assign rd_valid = rdv_q;
  assign rd_byte  = rdb_q;

  // R4
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_ack && !bus_reset) |=> $stable(act_q));
  // R6
  bus_reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (act_q.en && act_q.addr == '0 && !pend_q));
  // R3
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> (!rdv_q && rdb_q == '0));
  // R2
  write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !bus_reset) |=> (pend_q && shadow_q == $past(wr_byte)));
endmodule

// File: rtl/usb_addr_tok_match.sv
module usb_addr_tok_match
  import usb_addr_pkg::*;
(
  input  logic              tok_valid,
  input  logic [ADDR_W-1:0] tok_addr,
  input  dev_reg_t          act,
  output logic              match
);
  assign match = tok_valid && act.en && (tok_addr == act.addr);
endmodule

// File: rtl/usb_addr_unit.sv
module usb_addr_unit
  import usb_addr_pkg::*;
#(
  parameter int               DATA_W = 16,
  parameter int               CMD_W  = 8,
  parameter logic [CMD_W-1:0] CMD_WR = 8'hB6,
  parameter logic [CMD_W-1:0] CMD_RD = 8'hB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              bus_reset,
  input  logic              status_ack,
  input  logic              tok_valid,
  input  logic [ADDR_W-1:0] tok_addr,
  output logic              addr_match,
  output logic              dev_en,
  output logic [ADDR_W-1:0] dev_addr
);
  localparam int PAD_W = DATA_W - REG_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             wr_fire, rd_fire;
  logic [REG_W-1:0] rd_byte;
  dev_reg_t         act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  usb_addr_cmd_dec #(
    .CMD_W (CMD_W),
    .CMD_WR(CMD_WR),
    .CMD_RD(CMD_RD)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bus_reset(bus_reset),
    .cmd_valid(cmd_valid),
    .cmd_code (cmd_code),
    .wr_valid (wr_valid),
    .rd_req   (rd_req),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire)
  );

  usb_addr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_reset (bus_reset),
    .wr_fire   (wr_fire),
    .wr_byte   (wr_data[REG_W-1:0]),
    .rd_fire   (rd_fire),
    .status_ack(status_ack),
    .act       (act),
    .rd_valid  (rd_valid),
    .rd_byte   (rd_byte)
  );

  usb_addr_tok_match u_match (
    .tok_valid(tok_valid),
    .tok_addr (tok_addr),
    .act      (act),
    .match    (addr_match)
  );

  assign rd_data  = {{PAD_W{1'b0}}, rd_byte};
  assign dev_en   = act.en;
  assign dev_addr = act.addr;

  // R8
  match_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    addr_match |-> (dev_en && tok_valid && tok_addr == dev_addr));
  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_data[DATA_W-1:REG_W] == '0);
  // R1
  read_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_valid |-> $past(rd_req));
endmodule

// File: tb/test_usb_addr_unit.sv
module test_usb_addr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_code;
  logic        wr_valid;
  logic [15:0] wr_data;
  logic        rd_req;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        bus_reset;
  logic        status_ack;
  logic        tok_valid;
  logic [6:0]  tok_addr;
  logic        addr_match;
  logic        dev_en;
  logic [6:0]  dev_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  // model state
  logic [7:0] m_shadow;
  logic       m_pend;
  logic [7:0] m_act;
  int         m_cmd; // 0 none, 1 write, 2 read

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_addr_unit i_usb_addr_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .bus_reset(bus_reset),
    .status_ack(status_ack), .tok_valid(tok_valid), .tok_addr(tok_addr),
    .addr_match(addr_match), .dev_en(dev_en), .dev_addr(dev_addr)
  );

  function automatic logic exp_match(logic [7:0] a, logic v, logic [6:0] t);
    return v && a[7] && (t == a[6:0]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_act(string req);
    check(req, {dev_en, dev_addr}, m_act);
  endtask

  task automatic do_cmd(logic [7:0] code);
    @(negedge clk); cmd_valid = 1; cmd_code = code;
    @(negedge clk); cmd_valid = 0;
    m_cmd = (code == 8'hB6) ? 1 : (code == 8'hB7) ? 2 : 0;
  endtask

  task automatic do_wr(logic [15:0] d, string req);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
    if (m_cmd == 1) begin m_shadow = d[7:0]; m_pend = 1; end
    m_cmd = 0;
    chk_act(req); // R4: write alone never moves active register
  endtask

  task automatic do_rd(string req);
    logic ok;
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    ok = (m_cmd == 2);
    check(req, {15'd0, rd_valid}, {31'd0, ok});
    check(req, {16'd0, rd_data}, ok ? {24'd0, m_shadow} : 32'd0);
    m_cmd = 0;
    @(negedge clk);
    check("R3 pulse", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic do_ack(string req);
    @(negedge clk); status_ack = 1;
    @(negedge clk); status_ack = 0;
    if (m_pend) begin m_act = m_shadow; m_pend = 0; end
    chk_act(req);
  endtask

  task automatic do_busrst(string req);
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
    m_act = 8'h80; m_shadow = 8'h80; m_pend = 0; m_cmd = 0;
    chk_act(req);
  endtask

  task automatic do_tok(logic [6:0] a, logic v, string req);
    @(negedge clk); tok_valid = v; tok_addr = a;
    #1;
    check(req, {31'd0, addr_match}, {31'd0, exp_match(m_act, v, a)});
    tok_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_code = 0; wr_valid = 0; wr_data = 0;
    rd_req = 0; bus_reset = 0; status_ack = 0; tok_valid = 0; tok_addr = 0;
    m_shadow = 0; m_pend = 0; m_act = 0; m_cmd = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 en/addr", {dev_en, dev_addr}, 32'h00);
    check("R7 rd_valid", {31'd0, rd_valid}, 32'd0);
    tok_valid = 1; tok_addr = 0; #1;
    check("R7 match", {31'd0, addr_match}, 32'd0);
    tok_valid = 0;
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_act("R7 after release");

    // R2 R4 R5: write with junk upper byte, stays pending until ack
    do_cmd(8'hB6); do_wr(16'hA5C3, "R2 R4 pending");
    do_cmd(8'hB7); do_rd("R3 read pending value");
    do_tok(7'h43, 1, "R8 disabled no match");
    do_ack("R4 ack activates");
    check("R5 en bit", {31'd0, dev_en}, 32'd1);
    check("R5 addr bits", {25'd0, dev_addr}, 32'h43);
    do_tok(7'h43, 1, "R8 match");
    do_tok(7'h43, 0, "R8 tok_valid low");
    do_tok(7'h42, 1, "R8 mismatch");
    do_ack("R4 ack with none pending");
    // R9 second write with no command
    do_cmd(8'hB6); do_wr(16'h0011, "R9 first");
    do_wr(16'h0022, "R9 second ignored");
    do_rd("R9 read without command");
    do_cmd(8'hB7); do_rd("R9 readback");
    // R1 unknown command
    do_cmd(8'hB5); do_wr(16'h00FF, "R1 bad cmd write");
    do_cmd(8'h00); do_rd("R1 bad cmd read");
    // R6 bus reset with pending value
    do_cmd(8'hB6); do_wr(16'h0077, "R6 pre");
    do_busrst("R6 reset value");
    do_ack("R6 pending discarded");
    do_cmd(8'hB7); do_rd("R6 readback 0x80");
    do_tok(7'h00, 1, "R6 R8 addr 0 matches");
    // R6 command cancelled by bus reset
    do_cmd(8'hB6); do_busrst("R6 cancel"); do_wr(16'h0033, "R6 cancelled write");
    // two writes, then ack takes the latest
    do_cmd(8'hB6); do_wr(16'h0001, "R4 w1");
    do_cmd(8'hB6); do_wr(16'h0082, "R4 w2");
    do_ack("R4 latest pending wins");

    // random phase
    for (int i = 0; i < 1500; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: do_cmd(($urandom_range(0, 3) == 0) ? 8'($urandom) :
                     (($urandom_range(0, 1) == 0) ? 8'hB6 : 8'hB7));
        2, 3: do_wr(16'($urandom), "R2 R9 rnd write");
        4, 5: do_rd("R1 R3 rnd read");
        6:    do_ack("R4 rnd ack");
        7:    if ($urandom_range(0, 3) == 0) do_busrst("R6 rnd reset");
              else do_ack("R4 rnd ack2");
        default: do_tok(($urandom_range(0, 1) == 0) ? m_act[6:0] : 7'($urandom),
                        1'($urandom), "R8 rnd token");
      endcase
    end
    chk_act("R5 final");
    finish_run();
  end
endmodule